// File: doc/BRIEF.md
# DDS Control Word Loader

This block is the programming front end of a direct digital synthesizer. A host assembles a 40-bit programming word in a staging register. It can send the word as five bytes on an 8-bit bus, or as 40 single bits on the top bus line. A word-load clock marks each byte or bit. A separate update strobe copies the staged word into the active registers, which drive the tuning word, the phase word, the power-down flag and the test bits of the synthesis datapath.

Both strobes and the clear input come from outside the system clock domain. Each one passes through a two-flop synchronizer, and the strobes are then edge-detected, so one strobe pulse counts once however long it is held. In parallel mode a byte pointer selects the slot for each load. After the fifth load the pointer stays where it is, and only an update or a clear rearms it. The word is 40 bits: the control byte in bits 39:32 and the tuning word in bits 31:0. In the control byte, bits 7:3 are the phase word, bit 2 is power-down and bits 1:0 are test bits. The test bits should be zero. A nonzero value is still applied, and a fault output reports it.

Top module: `dds_word_loader`

## Requirements
- R1: After rst_ni is released, tuning_o, phase_o, power_down_o, test_bits_o and test_fault_o are all zero.
- R2: In parallel mode (serial_mode_i = 0), the five byte loads go to control byte [39:32], tuning [31:24], [23:16], [15:8] and [7:0], in that order.
- R3: After five parallel loads, further word-clock edges leave the staged word unchanged until an update or a clear.
- R4: A rising update edge copies the whole staged word to the outputs and returns the pointer to the control-byte slot.
- R5: In serial mode (serial_mode_i = 1), each word-clock edge shifts data_i[7] in at bit 39 and moves the word toward bit 0. The first of 40 bits ends up in bit 0, so the tuning word arrives least significant bit first, followed by the control byte.
- R6: Loads alone never change the outputs. Only an update edge does.
- R7: While clear_i is high, the outputs are held at zero and the pointer is rearmed. The staged word is kept, so an update after the clear applies it again.
- R8: The control byte maps to phase_o = bits 7:3, power_down_o = bit 2 and test_bits_o = bits 1:0.
- R9: test_fault_o is high exactly when the committed test bits are nonzero.
- R10: A word-clock pulse held high for many system clocks loads only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| serial_mode_i | input | 1 | 1 selects serial loading, 0 selects parallel |
| word_clk_i | input | 1 | Asynchronous word-load strobe |
| update_i | input | 1 | Asynchronous commit strobe |
| clear_i | input | 1 | Asynchronous master clear (level) |
| data_i | input | 8 | Byte bus; bit 7 is the serial line |
| tuning_o | output | 32 | Active frequency tuning word |
| phase_o | output | 5 | Active phase word |
| power_down_o | output | 1 | Active power-down flag |
| test_bits_o | output | 2 | Active test/mode bits |
| test_fault_o | output | 1 | Committed test bits are nonzero |

## Verification
The bench builds the block with its default parameters: a 32-bit tuning word, an 8-bit control byte with a 5-bit phase field, and two synchronizer stages. With two stages, every strobe edge reaches the registers within four system clocks. This lets the bench hold each strobe level for a few cycles and check the pointer saturation, the serial bit order, the clear-then-recommit sequence and the once-per-pulse loading of a long-held strobe exactly.

// File: rtl/dds_loader_pkg.sv
package dds_loader_pkg;
  typedef enum logic {
    LOAD_PAR = 1'b0,
    LOAD_SER = 1'b1
  } load_mode_e;

  function automatic int unsigned slot_ptr_w(int unsigned slots);
    return $clog2(slots + 1);
  endfunction
endpackage

// File: rtl/dds_strobe_sync.sv
module dds_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], async_i};
  end

  assign level_o = pipe_q[STAGES-1];
  assign rise_o  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/dds_stage_reg.sv
module dds_stage_reg #(
  parameter int unsigned WORD_W = 40,
  parameter int unsigned BUS_W  = 8,
  localparam int unsigned SLOTS = WORD_W / BUS_W,
  localparam int unsigned PTR_W = dds_loader_pkg::slot_ptr_w(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dds_loader_pkg::load_mode_e mode_i,
  input  logic              load_i,
  input  logic              rearm_i,
  input  logic [BUS_W-1:0]  data_i,
  output logic [WORD_W-1:0] word_o,
  output logic [PTR_W-1:0]  ptr_o
);
  import dds_loader_pkg::*;

  logic [WORD_W-1:0] word_q, word_d;
  logic [PTR_W-1:0]  ptr_q;
  logic              par_load, ser_shift;

  assign par_load  = load_i && !rearm_i && (mode_i == LOAD_PAR) && (ptr_q < PTR_W'(SLOTS));
  assign ser_shift = load_i && !rearm_i && (mode_i == LOAD_SER);

  always_comb begin
    word_d = word_q;
    if (ser_shift) begin
      word_d = {data_i[BUS_W-1], word_q[WORD_W-1:1]};
    end else if (par_load) begin
      for (int k = 0; k < int'(SLOTS); k++) begin
        if (ptr_q == PTR_W'(k)) word_d[WORD_W-1-k*BUS_W -: BUS_W] = data_i;
      end
    end
  end

  // staging word survives both resets by design
  always_ff @(posedge clk_i) word_q <= word_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (rearm_i)  ptr_q <= '0;
    else if (par_load) ptr_q <= ptr_q + 1'b1;
  end

  assign word_o = word_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/dds_active_reg.sv
module dds_active_reg #(
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned PHASE_W = 5,
  localparam int unsigned TEST_W = CTRL_W - PHASE_W - 1,
  localparam int unsigned WORD_W = FREQ_W + CTRL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  logic               clear_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [FREQ_W-1:0]  tuning_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               power_down_o,
  output logic [TEST_W-1:0]  test_bits_o,
  output logic               fault_o
);
  logic [FREQ_W-1:0] tuning_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic              fault_q;
  logic [CTRL_W-1:0] ctrl_in;

  assign ctrl_in = word_i[WORD_W-1 -: CTRL_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tuning_q <= '0;
      ctrl_q   <= '0;
      fault_q  <= 1'b0;
    end else if (clear_i) begin
      tuning_q <= '0;
      ctrl_q   <= '0;
      fault_q  <= 1'b0;
    end else if (commit_i) begin
      tuning_q <= word_i[FREQ_W-1:0];
      ctrl_q   <= ctrl_in;
      fault_q  <= |ctrl_in[TEST_W-1:0];
    end
  end

  assign tuning_o     = tuning_q;
  assign phase_o      = ctrl_q[CTRL_W-1 -: PHASE_W];
  assign power_down_o = ctrl_q[TEST_W];
  assign test_bits_o  = ctrl_q[TEST_W-1:0];
  assign fault_o      = fault_q;
endmodule

// File: rtl/dds_word_loader.sv
module dds_word_loader #(
  parameter int unsigned FREQ_W      = 32,
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned PHASE_W     = 5,
  parameter int unsigned BUS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            serial_mode_i,
  input  logic                            word_clk_i,
  input  logic                            update_i,
  input  logic                            clear_i,
  input  logic [BUS_W-1:0]                data_i,
  output logic [FREQ_W-1:0]               tuning_o,
  output logic [PHASE_W-1:0]              phase_o,
  output logic                            power_down_o,
  output logic [CTRL_W-PHASE_W-2:0]       test_bits_o,
  output logic                            test_fault_o
);
  import dds_loader_pkg::*;

  localparam int unsigned WORD_W = FREQ_W + CTRL_W;
  localparam int unsigned SLOTS  = WORD_W / BUS_W;
  localparam int unsigned PTR_W  = slot_ptr_w(SLOTS);

  logic              wclk_rise, upd_rise, clr_lvl;
  logic              wclk_lvl_unused, upd_lvl_unused, clr_rise_unused;
  logic [WORD_W-1:0] staged_word;
  logic [PTR_W-1:0]  slot_ptr;
  load_mode_e        load_mode;

  assign load_mode = serial_mode_i ? LOAD_SER : LOAD_PAR;

  dds_strobe_sync #(.STAGES(SYNC_STAGES)) u_wclk_sync (
    .clk_i, .rst_ni, .async_i(word_clk_i), .level_o(wclk_lvl_unused), .rise_o(wclk_rise)
  );
  dds_strobe_sync #(.STAGES(SYNC_STAGES)) u_upd_sync (
    .clk_i, .rst_ni, .async_i(update_i), .level_o(upd_lvl_unused), .rise_o(upd_rise)
  );
  dds_strobe_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .clk_i, .rst_ni, .async_i(clear_i), .level_o(clr_lvl), .rise_o(clr_rise_unused)
  );

  dds_stage_reg #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_stage (
    .clk_i, .rst_ni,
    .mode_i (load_mode),
    .load_i (wclk_rise),
    .rearm_i(upd_rise | clr_lvl),
    .data_i,
    .word_o (staged_word),
    .ptr_o  (slot_ptr)
  );

  dds_active_reg #(.FREQ_W(FREQ_W), .CTRL_W(CTRL_W), .PHASE_W(PHASE_W)) u_active (
    .clk_i, .rst_ni,
    .commit_i    (upd_rise),
    .clear_i     (clr_lvl),
    .word_i      (staged_word),
    .tuning_o,
    .phase_o,
    .power_down_o,
    .test_bits_o,
    .fault_o     (test_fault_o)
  );
endmodule

// File: rtl/dds_word_loader_chk.sv
module dds_word_loader_chk #(
  parameter int unsigned WORD_W  = 40,
  parameter int unsigned FREQ_W  = 32,
  parameter int unsigned PHASE_W = 5,
  parameter int unsigned SLOTS   = 5,
  parameter int unsigned PTR_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ser_mode,
  input logic               wclk_rise,
  input logic               upd_rise,
  input logic               clr,
  input logic [PTR_W-1:0]   ptr,
  input logic [WORD_W-1:0]  staged,
  input logic [FREQ_W-1:0]  tuning,
  input logic [PHASE_W-1:0] phase,
  input logic               pd,
  input logic               fault
);
  p_ptr_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr <= PTR_W'(SLOTS));

  p_sat_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_mode && wclk_rise && ptr == PTR_W'(SLOTS) && !upd_rise && !clr) |=> $stable(staged));

  p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_rise || clr) |=> ptr == '0);

  p_serial_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_mode && wclk_rise && !upd_rise && !clr) |=> staged[WORD_W-2:0] == $past(staged[WORD_W-1:1]));

  p_hold_until_update_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_rise && !clr) |=> ($stable(tuning) && $stable(phase) && $stable(pd)));

  p_clear_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr |=> (tuning == '0 && phase == '0 && !pd && !fault));

  p_fault_on_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault) |-> $past(upd_rise));
endmodule

bind dds_word_loader dds_word_loader_chk #(
  .WORD_W(WORD_W), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W), .SLOTS(SLOTS), .PTR_W(PTR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ser_mode (serial_mode_i),
  .wclk_rise(wclk_rise),
  .upd_rise (upd_rise),
  .clr      (clr_lvl),
  .ptr      (slot_ptr),
  .staged   (staged_word),
  .tuning   (tuning_o),
  .phase    (phase_o),
  .pd       (power_down_o),
  .fault    (test_fault_o)
);

// File: tb/dds_word_loader_test.sv
module dds_word_loader_test;
  typedef struct {
    logic [31:0] tuning;
    logic [4:0]  phase;
    logic        pd;
    logic [1:0]  tbits;
    logic        fault;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        serial_mode_i = 1'b0;
  logic        word_clk_i = 1'b0;
  logic        update_i = 1'b0;
  logic        clear_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [31:0] tuning_o;
  logic [4:0]  phase_o;
  logic        power_down_o;
  logic [1:0]  test_bits_o;
  logic        test_fault_o;

  int   total = 0;
  int   fails = 0;
  bit   done  = 0;
  exp_t sb_q[$];
  event check_ev;

  always #2 clk = ~clk;

  dds_word_loader uut (
    .clk_i(clk), .rst_ni, .serial_mode_i, .word_clk_i, .update_i, .clear_i, .data_i,
    .tuning_o, .phase_o, .power_down_o, .test_bits_o, .test_fault_o
  );

  function automatic exp_t mk(logic [31:0] t, logic [4:0] p, logic d, logic [1:0] b, string tag);
    exp_t e;
    e.tuning = t; e.phase = p; e.pd = d; e.tbits = b; e.fault = (b != 2'b00); e.tag = tag;
    return e;
  endfunction

  function automatic logic [7:0] ctrl(logic [4:0] p, logic d, logic [1:0] b);
    return {p, d, b};
  endfunction

  task automatic expect_out(exp_t e);
    sb_q.push_back(e);
    -> check_ev;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wclk_pulse(int hold);
    word_clk_i = 1'b1;
    repeat (hold) @(negedge clk);
    word_clk_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic update_pulse();
    update_i = 1'b1;
    repeat (4) @(negedge clk);
    update_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_par(logic [7:0] c, logic [31:0] t);
    serial_mode_i = 1'b0;
    data_i = c;          wclk_pulse(4);
    data_i = t[31:24];   wclk_pulse(4);
    data_i = t[23:16];   wclk_pulse(4);
    data_i = t[15:8];    wclk_pulse(4);
    data_i = t[7:0];     wclk_pulse(4);
  endtask

  task automatic send_ser(logic [7:0] c, logic [31:0] t);
    logic [39:0] w;
    w = {c, t};
    serial_mode_i = 1'b1;
    for (int i = 0; i < 40; i++) begin
      data_i = {w[i], 7'b0};
      wclk_pulse(4);
    end
  endtask

  // monitor: compares queued expectations with the outputs
  initial begin
    forever begin
      @(check_ev);
      @(negedge clk);
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        total++;
        if (tuning_o !== e.tuning || phase_o !== e.phase || power_down_o !== e.pd ||
            test_bits_o !== e.tbits || test_fault_o !== e.fault) begin
          fails++;
          $display("FAIL %s: got t=%h p=%h pd=%b tb=%b f=%b exp t=%h p=%h pd=%b tb=%b f=%b",
                   e.tag, tuning_o, phase_o, power_down_o, test_bits_o, test_fault_o,
                   e.tuning, e.phase, e.pd, e.tbits, e.fault);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    expect_out(mk('0, '0, 0, 2'b00, "R1 reset state"));

    // R2 R8 R4: parallel word with phase 5, power-down set
    send_par(ctrl(5'd5, 1, 2'b00), 32'h1234_5678);
    expect_out(mk('0, '0, 0, 2'b00, "R6 no change before update"));
    update_pulse();
    expect_out(mk(32'h1234_5678, 5'd5, 1, 2'b00, "R2 R8 parallel order and fields"));

    // R3: sixth byte ignored
    send_par(ctrl(5'd17, 0, 2'b00), 32'hCAFE_0042);
    data_i = 8'hFF; wclk_pulse(4);
    expect_out(mk(32'h1234_5678, 5'd5, 1, 2'b00, "R6 outputs held during loads"));
    update_pulse();
    expect_out(mk(32'hCAFE_0042, 5'd17, 0, 2'b00, "R3 saturated pointer ignores edge"));

    // R4: pointer rearmed, R10: one long pulse loads once
    serial_mode_i = 1'b0;
    data_i = ctrl(5'd30, 1, 2'b00); wclk_pulse(20);
    data_i = 8'h0B; wclk_pulse(4);
    data_i = 8'h0C; wclk_pulse(15);
    data_i = 8'h0D; wclk_pulse(4);
    data_i = 8'h0E; wclk_pulse(4);
    update_pulse();
    expect_out(mk(32'h0B0C_0D0E, 5'd30, 1, 2'b00, "R4 R10 rearm and long pulse single load"));

    // R5: serial word
    send_ser(ctrl(5'd31, 0, 2'b00), 32'hA5C3_0F1E);
    update_pulse();
    expect_out(mk(32'hA5C3_0F1E, 5'd31, 0, 2'b00, "R5 serial lsb first"));

    // R9: nonzero test bits
    send_ser(ctrl(5'd2, 0, 2'b01), 32'h0000_0100);
    update_pulse();
    expect_out(mk(32'h0000_0100, 5'd2, 0, 2'b01, "R9 test bits flagged"));
    send_ser(ctrl(5'd2, 0, 2'b10), 32'h0000_0200);
    update_pulse();
    expect_out(mk(32'h0000_0200, 5'd2, 0, 2'b10, "R9 other test bit flagged"));
    send_ser(ctrl(5'd3, 1, 2'b00), 32'h8000_0001);
    update_pulse();
    expect_out(mk(32'h8000_0001, 5'd3, 1, 2'b00, "R9 fault clears on clean word"));

    // R7: clear zeroes outputs, keeps staged word
    clear_i = 1'b1;
    repeat (6) @(negedge clk);
    expect_out(mk('0, '0, 0, 2'b00, "R7 clear zeroes outputs"));
    clear_i = 1'b0;
    repeat (4) @(negedge clk);
    expect_out(mk('0, '0, 0, 2'b00, "R7 outputs stay zero after clear"));
    update_pulse();
    expect_out(mk(32'h8000_0001, 5'd3, 1, 2'b00, "R7 staged word survives clear"));

    // R7: clear rearms pointer mid-sequence
    serial_mode_i = 1'b0;
    data_i = 8'h77; wclk_pulse(4);
    data_i = 8'h66; wclk_pulse(4);
    clear_i = 1'b1;
    repeat (6) @(negedge clk);
    clear_i = 1'b0;
    repeat (4) @(negedge clk);
    send_par(ctrl(5'd9, 0, 2'b11), 32'hDEAD_BEEF);
    update_pulse();
    expect_out(mk(32'hDEAD_BEEF, 5'd9, 0, 2'b11, "R7 R2 clear rearms pointer"));

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule